// File: doc/BRIEF.md
# Machine Performance Counter Bank

This block holds the machine-level performance counters of a processor core and sits in its control and status register (CSR) space. It has a free-running 64-bit cycle counter, a 64-bit counter of retired instructions, and a parameterised set of general event counters. There are 29 of these by default, numbered 3 to 31. Each general counter has its own selector register, which chooses one line of the core's event vector. One inhibit register can freeze any counter independently of the others. Each 64-bit counter is split into two 32-bit CSRs: one for its low word and one for its high word.

The core decodes a CSR instruction and presents the access on a single-cycle request port. The port carries a 12-bit address, a 2-bit operation code and a 32-bit operand. For the immediate forms of the instructions, the core supplies the zero-extended immediate as the operand. Read data and an illegal-access flag come back combinationally in the same cycle and show the state before the access. Any update takes effect at the next rising clock edge.

The counters advance every cycle from the event vector. Line 0 of that vector is the instruction-retire pulse.

Top module: `perf_counter_bank`

## Requirements
- R1: After reset, all counters, all selectors and the inhibit register read zero, so every counter is enabled.
- R2: The cycle counter (low word at 0xB00, high word at 0xB80) adds one on every clock edge at which inhibit bit 0 is clear.
- R3: The retired-instruction counter (0xB02 / 0xB82) adds one on every edge at which event line 0 is high and inhibit bit 2 is clear.
- R4: Event counter j (0xB00+j / 0xB80+j) adds one on every edge at which its selector (0x320+j) holds a value s from 1 to NumEventLines, event line s-1 is high, and inhibit bit j is clear. A selector value of 0, or above NumEventLines, counts nothing. A selector keeps only its low $clog2(NumEventLines+1) bits and reads back zero-extended.
- R5: The inhibit register is at 0x320. Bit 0 freezes the cycle counter, bit 2 freezes the retired-instruction counter, and bit j freezes event counter j. Bit 1 and the bits of absent counters read zero and ignore writes.
- R6: csrOp encodings: 00 reads only, 01 writes the operand, 10 sets the operand's bits, 11 clears the operand's bits. csrRdata returns the old value in the same cycle, and the new value is stored at the next edge.
- R7: A write to a counter word takes priority over that word's increment on the same edge. A write to the high word does not stop the low word from counting.
- R8: When an increment wraps the low word from 0xFFFFFFFF to 0, the high word adds one on the same edge.
- R9: An access to 0xB01, 0xB81, 0x321 or 0x322 raises csrIllegal, returns zero and changes nothing. An address outside the three windows 0x320–0x33F, 0xB00–0xB1F and 0xB80–0xB9F returns zero with csrIllegal low.
- R10: While csrReq is low, csrRdata and csrIllegal are zero and no register is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csrReq | input | 1 | CSR access valid this cycle |
| csrAddr | input | 12 | CSR address |
| csrOp | input | 2 | 00 read, 01 write, 10 set bits, 11 clear bits |
| csrWdata | input | 32 | Operand (register value or zero-extended immediate) |
| eventVec | input | NumEventLines | Per-cycle event pulses; line 0 is instruction retire |
| csrRdata | output | 32 | Value of the addressed register before the access |
| csrIllegal | output | 1 | Access to an unimplemented address in the counter windows |

## Verification
The assertions check the following on every cycle:
- an idle port is quiet;
- an illegal access returns zero and writes nothing;
- a pure read never creates a write strobe;
- inhibit bit 1 always reads zero;
- a cycle-counter write followed by a read returns exactly the written word, which shows that the write beat the increment.

Only the bench scenarios can show the counting itself. They check exact totals after a known event pattern, with every selector value swept and some counters inhibited. They also check the carry into the high word, the operand masking of the selectors and inhibit register, and the full sweep of illegal addresses.

// File: rtl/perf_ctr_pkg.sv
package perf_ctr_pkg;

  localparam int CsrWidth = 32;

  // Upper seven address bits of each 32-entry window
  localparam logic [6:0] LowWindow  = 7'h58;  // 0xB00
  localparam logic [6:0] HighWindow = 7'h5C;  // 0xB80
  localparam logic [6:0] CfgWindow  = 7'h19;  // 0x320

  typedef enum logic [2:0] {
    KindNone,
    KindLow,
    KindHigh,
    KindSel,
    KindInh
  } regKind_e;

  typedef enum logic [1:0] {
    OpRead  = 2'b00,
    OpWrite = 2'b01,
    OpSet   = 2'b10,
    OpClear = 2'b11
  } csrOp_e;

  typedef struct packed {
    regKind_e              kind;
    logic [4:0]            idx;
    logic                  wrEn;
    logic [CsrWidth-1:0]   wval;
  } csrStrobe_t;

endpackage

// File: rtl/perf_ctr_ctrl.sv
module perf_ctr_ctrl
  import perf_ctr_pkg::*;
#(
  parameter int NumHpm = 29
) (
  input  logic                csrReq,
  input  logic [11:0]         csrAddr,
  input  logic [1:0]          csrOp,
  input  logic [CsrWidth-1:0] csrWdata,
  input  logic [CsrWidth-1:0] readVal,
  output csrStrobe_t          strobe,
  output logic [CsrWidth-1:0] csrRdata,
  output logic                csrIllegal
);

  localparam logic [4:0] LastIdx = 5'(2 + NumHpm);

  logic [4:0]          idx;
  logic [6:0]          window;
  logic                inWindow;
  logic                ctrOk;
  regKind_e            kind;
  logic [CsrWidth-1:0] newVal;

  always_comb begin
    idx      = csrAddr[4:0];
    window   = csrAddr[11:5];
    inWindow = csrReq && (window == LowWindow || window == HighWindow ||
                          window == CfgWindow);
    ctrOk    = (idx == 5'd0) || (idx >= 5'd2 && idx <= LastIdx);
    kind     = KindNone;
    if (csrReq) begin
      case (window)
        LowWindow:  if (ctrOk) kind = KindLow;
        HighWindow: if (ctrOk) kind = KindHigh;
        CfgWindow: begin
          if (idx == 5'd0) kind = KindInh;
          else if (idx >= 5'd3 && idx <= LastIdx) kind = KindSel;
        end
        default: kind = KindNone;
      endcase
    end
  end

  always_comb begin
    case (csrOp_e'(csrOp))
      OpWrite: newVal = csrWdata;
      OpSet:   newVal = readVal | csrWdata;
      OpClear: newVal = readVal & ~csrWdata;
      default: newVal = readVal;
    endcase
  end

  always_comb begin
    strobe.kind = kind;
    strobe.idx  = idx;
    strobe.wrEn = (kind != KindNone) && (csrOp_e'(csrOp) != OpRead);
    strobe.wval = newVal;
    csrRdata    = (kind != KindNone) ? readVal : '0;
    csrIllegal  = inWindow && (kind == KindNone);
  end

endmodule

// File: rtl/perf_ctr_dp.sv
module perf_ctr_dp
  import perf_ctr_pkg::*;
#(
  parameter int NumHpm        = 29,
  parameter int NumEventLines = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  csrStrobe_t               strobe,
  input  logic [NumEventLines-1:0] eventVec,
  output logic [CsrWidth-1:0]      readVal
);

  localparam int SelWidth = $clog2(NumEventLines + 1);
  localparam int PadWidth = 2 ** SelWidth;
  localparam int LastIdx  = 2 + NumHpm;

  function automatic logic [CsrWidth-1:0] implMask();
    logic [CsrWidth-1:0] m;
    for (int k = 0; k < CsrWidth; k++) begin
      m[k] = (k == 0) || (k >= 2 && k <= LastIdx);
    end
    return m;
  endfunction

  localparam logic [CsrWidth-1:0] ImplMask = implMask();

  logic [CsrWidth-1:0] lowBus  [32];
  logic [CsrWidth-1:0] highBus [32];
  logic [CsrWidth-1:0] selBus  [32];
  logic [CsrWidth-1:0] inhibit;
  logic [PadWidth-1:0] evPad;

  // Line s-1 appears at position s; position 0 and any beyond the lines stay low
  assign evPad = PadWidth'({eventVec, 1'b0});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inhibit <= '0;
    end else if (strobe.wrEn && strobe.kind == KindInh) begin
      inhibit <= strobe.wval & ImplMask;
    end
  end

  for (genvar i = 0; i < 32; i++) begin : g_ctr
    if (i == 0 || (i >= 2 && i <= LastIdx)) begin : g_impl
      logic                evHit;
      logic                incr;
      logic                lowWr;
      logic                highWr;
      logic [CsrWidth-1:0] lowQ;
      logic [CsrWidth-1:0] highQ;

      if (i >= 3) begin : g_hpm
        logic [SelWidth-1:0] selQ;
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) begin
            selQ <= '0;
          end else if (strobe.wrEn && strobe.kind == KindSel && strobe.idx == 5'(i)) begin
            selQ <= strobe.wval[SelWidth-1:0];
          end
        end
        assign evHit     = evPad[selQ];
        assign selBus[i] = CsrWidth'(selQ);
      end else begin : g_fixed
        if (i == 0) begin : g_cycle
          assign evHit = 1'b1;
        end else begin : g_ret
          assign evHit = eventVec[0];
        end
        assign selBus[i] = '0;
      end

      assign incr   = evHit && !inhibit[i];
      assign lowWr  = strobe.wrEn && strobe.kind == KindLow  && strobe.idx == 5'(i);
      assign highWr = strobe.wrEn && strobe.kind == KindHigh && strobe.idx == 5'(i);

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          lowQ  <= '0;
          highQ <= '0;
        end else begin
          if (lowWr)       lowQ <= strobe.wval;
          else if (incr)   lowQ <= lowQ + 1'b1;
          if (highWr)      highQ <= strobe.wval;
          else if (incr && !lowWr && (&lowQ)) highQ <= highQ + 1'b1;
        end
      end

      assign lowBus[i]  = lowQ;
      assign highBus[i] = highQ;
    end else begin : g_absent
      assign lowBus[i]  = '0;
      assign highBus[i] = '0;
      assign selBus[i]  = '0;
    end
  end

  always_comb begin
    case (strobe.kind)
      KindLow:  readVal = lowBus[strobe.idx];
      KindHigh: readVal = highBus[strobe.idx];
      KindSel:  readVal = selBus[strobe.idx];
      KindInh:  readVal = inhibit;
      default:  readVal = '0;
    endcase
  end

endmodule

// File: rtl/perf_counter_bank.sv
module perf_counter_bank
  import perf_ctr_pkg::*;
#(
  parameter int NumHpm        = 29,
  parameter int NumEventLines = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     csrReq,
  input  logic [11:0]              csrAddr,
  input  logic [1:0]               csrOp,
  input  logic [31:0]              csrWdata,
  input  logic [NumEventLines-1:0] eventVec,
  output logic [31:0]              csrRdata,
  output logic                     csrIllegal
);

  csrStrobe_t          strobe;
  logic [CsrWidth-1:0] readVal;

  perf_ctr_ctrl #(.NumHpm(NumHpm)) i_ctrl (
    .csrReq    (csrReq),
    .csrAddr   (csrAddr),
    .csrOp     (csrOp),
    .csrWdata  (csrWdata),
    .readVal   (readVal),
    .strobe    (strobe),
    .csrRdata  (csrRdata),
    .csrIllegal(csrIllegal)
  );

  perf_ctr_dp #(.NumHpm(NumHpm), .NumEventLines(NumEventLines)) i_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .eventVec(eventVec),
    .readVal (readVal)
  );

endmodule

// File: rtl/perf_ctr_chk.sv
module perf_ctr_chk
  import perf_ctr_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        csrReq,
  input logic [11:0] csrAddr,
  input logic [1:0]  csrOp,
  input logic [31:0] csrWdata,
  input logic [31:0] csrRdata,
  input logic        csrIllegal,
  input csrStrobe_t  strobe
);

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !csrReq |-> (csrRdata == '0 && !csrIllegal && !strobe.wrEn));

  // R9
  illegal_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    csrIllegal |-> (csrRdata == '0 && !strobe.wrEn));

  // R6
  read_nowrite_chk: assert property (@(posedge clk) disable iff (!rstN)
    (csrReq && csrOp == 2'b00) |-> !strobe.wrEn);

  // R5
  inh_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (csrReq && csrAddr == 12'h320) |-> !csrRdata[1]);

  // R7
  wr_then_rd_chk: assert property (@(posedge clk) disable iff (!rstN)
    (csrReq && csrAddr == 12'hB00 && csrOp == 2'b01) ##1
    (csrReq && csrAddr == 12'hB00 && csrOp == 2'b00)
    |-> csrRdata == $past(csrWdata));

endmodule

bind perf_counter_bank perf_ctr_chk i_chk (
  .clk       (clk),
  .rstN      (rstN),
  .csrReq    (csrReq),
  .csrAddr   (csrAddr),
  .csrOp     (csrOp),
  .csrWdata  (csrWdata),
  .csrRdata  (csrRdata),
  .csrIllegal(csrIllegal),
  .strobe    (strobe)
);

// File: tb/test_perf_counter_bank.sv
`timescale 1ns/1ps
module test_perf_counter_bank;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        csrReq = 1'b0;
  logic [11:0] csrAddr = '0;
  logic [1:0]  csrOp = '0;
  logic [31:0] csrWdata = '0;
  logic [15:0] eventVec = '0;
  logic [31:0] csrRdata;
  logic        csrIllegal;

  int checks = 0;
  int errors = 0;
  int evCnt [16];

  always #4 clk = ~clk;

  perf_counter_bank i_perf_counter_bank (
    .clk(clk), .rstN(rstN), .csrReq(csrReq), .csrAddr(csrAddr), .csrOp(csrOp),
    .csrWdata(csrWdata), .eventVec(eventVec), .csrRdata(csrRdata),
    .csrIllegal(csrIllegal)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Combinational read, consumes no clock edge; called at a falling edge
  task automatic rdCsr(input logic [11:0] a, output logic [31:0] d, output logic il);
    csrReq = 1'b1; csrAddr = a; csrOp = 2'b00; csrWdata = '0;
    #1;
    d = csrRdata; il = csrIllegal;
    csrReq = 1'b0;
  endtask

  // Modifying access, consumes one rising edge; ends at a falling edge
  task automatic opCsr(input logic [11:0] a, input logic [1:0] op, input logic [31:0] w,
                       output logic il);
    csrReq = 1'b1; csrAddr = a; csrOp = op; csrWdata = w;
    #1;
    il = csrIllegal;
    @(posedge clk);
    @(negedge clk);
    csrReq = 1'b0; csrOp = 2'b00;
  endtask

  function automatic logic [15:0] pat(input int c);
    return 16'(c * 14939) ^ 16'(c << 5);
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    logic [31:0] rd;
    logic        il;
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rdCsr(12'h320, rd, il); chk("R1 inhibit", rd, 32'h0);
    rdCsr(12'h324, rd, il); chk("R1 selector", rd, 32'h0);
    rdCsr(12'hB03, rd, il); chk("R1 event counter", rd, 32'h0);

    // R9 sweep of the three windows
    for (int w = 0; w < 3; w++) begin
      for (int k = 0; k < 32; k++) begin
        logic [11:0] a;
        logic        expIl;
        a = (w == 0) ? 12'h320 + 12'(k) : (w == 1) ? 12'hB00 + 12'(k) : 12'hB80 + 12'(k);
        expIl = (a == 12'hB01 || a == 12'hB81 || a == 12'h321 || a == 12'h322);
        rdCsr(a, rd, il);
        chk("R9 illegal flag", {31'b0, il}, {31'b0, expIl});
        if (expIl) chk("R9 illegal data", rd, 32'h0);
      end
    end
    rdCsr(12'h300, rd, il);
    chk("R9 outside data", rd, 32'h0);
    chk("R9 outside flag", {31'b0, il}, 32'h0);
    opCsr(12'h321, 2'b01, 32'hFF, il);
    chk("R9 illegal write flag", {31'b0, il}, 32'h1);
    rdCsr(12'h320, rd, il); chk("R9 illegal write no effect", rd, 32'h0);

    // R10 idle port
    csrAddr = 12'h320; csrOp = 2'b01; csrWdata = 32'h5; #1;
    chk("R10 idle data", csrRdata, 32'h0);
    chk("R10 idle flag", {31'b0, csrIllegal}, 32'h0);
    @(posedge clk); @(negedge clk); csrOp = 2'b00;
    rdCsr(12'h320, rd, il); chk("R10 idle no write", rd, 32'h0);

    // R2 / R7 cycle counter
    opCsr(12'hB00, 2'b01, 32'h0, il);
    rdCsr(12'hB00, rd, il); chk("R7 cycle write wins", rd, 32'h0);
    repeat (10) @(negedge clk);
    rdCsr(12'hB00, rd, il); chk("R2 cycle count", rd, 32'd10);

    // R5 inhibit freezes cycle counter; masking
    opCsr(12'h320, 2'b01, 32'h1, il);
    rdCsr(12'hB00, rd, il); v = rd;
    repeat (5) @(negedge clk);
    rdCsr(12'hB00, rd, il); chk("R5 cycle frozen", rd, v);
    opCsr(12'h320, 2'b01, 32'hFFFF_FFFF, il);
    rdCsr(12'h320, rd, il); chk("R5 inhibit mask", rd, 32'hFFFF_FFFD);
    opCsr(12'h320, 2'b11, 32'h1, il);
    rdCsr(12'h320, rd, il); chk("R6 clear op", rd, 32'hFFFF_FFFC);
    opCsr(12'h320, 2'b01, 32'h0, il);

    // R8 carry
    opCsr(12'hB80, 2'b01, 32'd5, il);
    opCsr(12'hB00, 2'b01, 32'hFFFF_FFFE, il);
    rdCsr(12'hB80, rd, il); chk("R8 high before", rd, 32'd5);
    repeat (2) @(negedge clk);
    rdCsr(12'hB80, rd, il); chk("R8 high after carry", rd, 32'd6);
    rdCsr(12'hB00, rd, il); chk("R8 low wrapped", rd, 32'd0);

    // R3 / R4 selector and event sweep
    for (int j = 3; j < 32; j++) begin
      opCsr(12'h320 + 12'(j), 2'b01, 32'hFFFF_FFE0 | 32'(j - 3), il);
      opCsr(12'hB00 + 12'(j), 2'b01, 32'h0, il);
      opCsr(12'hB80 + 12'(j), 2'b01, 32'h0, il);
    end
    for (int j = 3; j < 32; j++) begin
      rdCsr(12'h320 + 12'(j), rd, il); chk("R4 selector readback", rd, 32'(j - 3));
    end
    opCsr(12'hB02, 2'b01, 32'h0, il);
    opCsr(12'hB82, 2'b01, 32'h0, il);
    opCsr(12'h320, 2'b01, (32'h1 << 5) | (32'h1 << 30), il);
    for (int k = 0; k < 16; k++) evCnt[k] = 0;
    for (int c = 0; c < 40; c++) begin
      eventVec = pat(c);
      for (int k = 0; k < 16; k++) if (pat(c)[k]) evCnt[k]++;
      @(negedge clk);
    end
    eventVec = '0;
    rdCsr(12'hB02, rd, il); chk("R3 retired count", rd, 32'(evCnt[0]));
    for (int j = 3; j < 32; j++) begin
      int s;
      logic [31:0] e;
      s = j - 3;
      e = (s >= 1 && s <= 16 && j != 5) ? 32'(evCnt[s-1]) : 32'h0;
      rdCsr(12'hB00 + 12'(j), rd, il); chk("R4 event count", rd, e);
      rdCsr(12'hB80 + 12'(j), rd, il); chk("R4 event high", rd, 32'h0);
    end

    // R6 set / clear on a selector
    opCsr(12'h323, 2'b10, 32'h3, il);
    rdCsr(12'h323, rd, il); chk("R6 set op", rd, 32'h3);
    opCsr(12'h323, 2'b11, 32'h1, il);
    rdCsr(12'h323, rd, il); chk("R6 clear op sel", rd, 32'h2);

    // R7 write priority on event counter 4 (line 0)
    eventVec = 16'h0001;
    opCsr(12'hB04, 2'b01, 32'd100, il);
    rdCsr(12'hB04, rd, il); chk("R7 low write wins", rd, 32'd100);
    repeat (3) @(negedge clk);
    rdCsr(12'hB04, rd, il); chk("R7 counting resumes", rd, 32'd103);
    opCsr(12'hB84, 2'b01, 32'd7, il);
    rdCsr(12'hB04, rd, il); chk("R7 high write keeps low counting", rd, 32'd104);
    rdCsr(12'hB84, rd, il); chk("R7 high written", rd, 32'd7);
    eventVec = '0;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule